// File: doc/BRIEF.md
# Iterative Signed Multiply-Divide Unit

This block performs signed integer multiplication and division on two operands over many clock cycles, using a single shared datapath. A request is issued by raising a start strobe together with an operation code and two operands. The unit then spends one cycle per operand bit on the core loop and one final cycle on sign correction and result selection. After that it presents the answer with a one-cycle completion strobe.

Multiplication accumulates the multiplicand into a running partial sum once for each multiplier bit, and keeps the full double-width product. Division is restoring: it shifts the dividend in one bit per cycle and subtracts the divisor whenever the difference does not borrow. Both loops work on operand magnitudes. Signs are restored at the end, so the quotient truncates toward zero and the remainder follows the dividend's sign. Division by zero and the single overflowing signed quotient return fixed, defined values.

Top module: `muldiv_iter`

## Requirements
- R1: With op code 0, the result is the low XLEN bits of the signed product a*b.
- R2: With op code 1, the result is the high XLEN bits of the full 2*XLEN-bit signed product a*b.
- R3: With op code 2, the result is the signed quotient a/b, truncated toward zero.
- R4: With op code 3, the result is the signed remainder, which has the dividend's sign and satisfies a = q*b + r.
- R5: When b is zero, op 2 returns all ones and op 3 returns a unchanged.
- R6: For a = -2^(XLEN-1) and b = -1, op 2 returns -2^(XLEN-1) and op 3 returns 0.
- R7: done_o is high for exactly one cycle, XLEN+1 cycles after the clock edge that accepts start_i.
- R8: busy_o rises in the cycle after a start is accepted and falls in the cycle where done_o is high. A start_i raised while busy_o is high is ignored and does not change the result.
- R9: result_o changes only in a cycle where done_o is high, and otherwise holds its value.
- R10: After reset, busy_o, done_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| op_i | input | 2 | 0 low product, 1 high product, 2 quotient, 3 remainder |
| a_i | input | XLEN | Multiplicand or dividend (signed) |
| b_i | input | XLEN | Multiplier or divisor (signed) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | XLEN | Result, held until the next completion |

## Verification
The bench builds the unit with its default XLEN of 32. This puts the most negative operand, the overflowing quotient and 64-bit products within reach, and the bench's integer reference arithmetic can compute all of them. Its model tracks the expected busy, done and held result every clock. This lets the cycle timing, the ignored mid-operation starts and the back-to-back requests that are issued on a done cycle be judged alongside the arithmetic values.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      OP_MUL  = 2'd0,
      OP_MULH = 2'd1,
      OP_DIV  = 2'd2,
      OP_REM  = 2'd3
   } md_op_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RUN  = 2'd1,
      S_FIX  = 2'd2
   } md_state_e;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic fin_o,
   output logic busy_o
);
   localparam int CW = $clog2(XLEN);

   md_state_e       state_q;
   logic [CW-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               state_q <= S_RUN;
               cnt_q   <= CW'(XLEN - 1);
            end
            S_RUN: begin
               if (cnt_q == '0) state_q <= S_FIX;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign load_o = start_i && (state_q == S_IDLE);
   assign step_o = (state_q == S_RUN);
   assign fin_o  = (state_q == S_FIX);
   assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  md_op_e          op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output md_op_e          op_o,
   output logic [XLEN-1:0] hi_o,
   output logic [XLEN-1:0] lo_o,
   output logic            sa_o,
   output logic            sb_o,
   output logic            bz_o
);
   localparam int MSB = XLEN - 1;

   logic [XLEN-1:0] hi_q, lo_q, mc_q;
   md_op_e          op_q;
   logic            sa_q, sb_q, bz_q;

   logic            is_div;
   logic [XLEN:0]   add_sum;
   logic [XLEN:0]   shifted;
   logic [XLEN:0]   diff;
   logic [XLEN-1:0] mag_a, mag_b;

   assign is_div  = (op_q == OP_DIV) || (op_q == OP_REM);
   assign mag_a   = a_i[MSB] ? (~a_i + 1'b1) : a_i;
   assign mag_b   = b_i[MSB] ? (~b_i + 1'b1) : b_i;
   assign add_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
   assign shifted = {hi_q, lo_q[MSB]};
   assign diff    = shifted - {1'b0, mc_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
         mc_q <= '0;
         op_q <= OP_MUL;
         sa_q <= 1'b0;
         sb_q <= 1'b0;
         bz_q <= 1'b0;
      end else if (load_i) begin
         hi_q <= '0;
         lo_q <= mag_a;
         mc_q <= mag_b;
         op_q <= op_i;
         sa_q <= a_i[MSB];
         sb_q <= b_i[MSB];
         bz_q <= (b_i == '0);
      end else if (step_i) begin
         if (is_div) begin
            hi_q <= diff[XLEN] ? shifted[MSB:0] : diff[MSB:0];
            lo_q <= {lo_q[MSB-1:0], ~diff[XLEN]};
         end else begin
            hi_q <= add_sum[XLEN:1];
            lo_q <= {add_sum[0], lo_q[MSB:1]};
         end
      end
   end

   assign op_o = op_q;
   assign hi_o = hi_q;
   assign lo_o = lo_q;
   assign sa_o = sa_q;
   assign sb_o = sb_q;
   assign bz_o = bz_q;
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  md_op_e          op_i,
   input  logic [XLEN-1:0] hi_i,
   input  logic [XLEN-1:0] lo_i,
   input  logic            sa_i,
   input  logic            sb_i,
   input  logic            bz_i,
   output logic [XLEN-1:0] res_o
);
   localparam int PW = 2 * XLEN;

   logic            neg;
   logic [PW-1:0]   prod, prod_s;
   logic [XLEN-1:0] quo_s, rem_s;

   assign neg    = sa_i ^ sb_i;
   assign prod   = {hi_i, lo_i};
   assign prod_s = neg ? (~prod + 1'b1) : prod;
   assign quo_s  = bz_i ? '1 : (neg ? (~lo_i + 1'b1) : lo_i);
   assign rem_s  = sa_i ? (~hi_i + 1'b1) : hi_i;

   always_comb begin
      case (op_i)
         OP_MUL:  res_o = prod_s[XLEN-1:0];
         OP_MULH: res_o = prod_s[PW-1:XLEN];
         OP_DIV:  res_o = quo_s;
         default: res_o = rem_s;
      endcase
   end
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);
   generate
      if (XLEN < 4 || XLEN > 64) begin : g_bad_xlen
         $error("muldiv_iter: XLEN must lie in 4..64");
      end
   endgenerate

   logic            load, step, fin;
   md_op_e          op_q;
   logic [XLEN-1:0] hi, lo, res;
   logic            sa, sb, bz;
   logic            done_q;
   logic [XLEN-1:0] result_q;

   muldiv_seq #(.XLEN(XLEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy_o)
   );

   muldiv_core #(.XLEN(XLEN)) u_core (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .op_i(md_op_e'(op_i)), .a_i(a_i), .b_i(b_i),
      .op_o(op_q), .hi_o(hi), .lo_o(lo), .sa_o(sa), .sb_o(sb), .bz_o(bz)
   );

   muldiv_fix #(.XLEN(XLEN)) u_fix (
      .op_i(op_q), .hi_i(hi), .lo_i(lo), .sa_i(sa), .sb_i(sb), .bz_i(bz),
      .res_o(res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= fin;
         if (fin) result_q <= res;
      end
   end

   assign done_o   = done_q;
   assign result_o = result_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [1:0]      op_i,
   input logic [XLEN-1:0] b_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [XLEN-1:0] result_o
);
   logic [15:0] lat_q;
   logic [1:0]  op_cap;
   logic        bz_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q  <= '0;
         op_cap <= '0;
         bz_cap <= 1'b0;
      end else if (start_i && !busy_o) begin
         lat_q  <= '0;
         op_cap <= op_i;
         bz_cap <= (b_i == '0);
      end else if (busy_o) begin
         lat_q  <= lat_q + 1'b1;
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == 16'(XLEN + 1)));

   p_busy_low_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   p_divzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && op_cap == 2'd2 && bz_cap) |-> (result_o == '1));
endmodule

bind muldiv_iter muldiv_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .b_i(b_i),
   .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/muldiv_iter_tb_top.sv
module muldiv_iter_tb_top;
   localparam int XLEN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = '0;
   logic [31:0] a = '0, b = '0;
   logic        busy, done;
   logic [31:0] result;

   always #10 clk = ~clk;

   muldiv_iter #(.XLEN(XLEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
      .busy_o(busy), .done_o(done), .result_o(result)
   );

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_res(input logic [1:0] o,
                                           input logic [31:0] x, input logic [31:0] y);
      longint p;
      int     xi, yi;
      xi = int'(x);
      yi = int'(y);
      p  = longint'(xi) * longint'(yi);
      case (o)
         2'd0: return p[31:0];
         2'd1: return p[63:32];
         2'd2: begin
            if (y == 0) return 32'hFFFF_FFFF;
            if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return x;
            return 32'(xi / yi);
         end
         default: begin
            if (y == 0) return x;
            if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 0;
            return 32'(xi % yi);
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] o, input logic [31:0] x,
                                    input logic [31:0] y);
      if (o >= 2 && y == 0) return "R5 div-by-zero";
      if (o >= 2 && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R6 overflow";
      case (o)
         2'd0:    return "R1 mul low";
         2'd1:    return "R2 mul high";
         2'd2:    return "R3 quotient";
         default: return "R4 remainder";
      endcase
   endfunction

   // Behavioural reference: remaining cycles, expected result, held value
   int          m_left = 0;
   bit          m_done = 0;
   logic [31:0] m_exp = '0, m_res = '0;
   string       m_tag = "";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_left = 0; m_done = 0; m_res = '0;
      end else begin
         m_done = 0;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
               m_done = 1;
               m_res  = m_exp;
            end
         end else if (start) begin
            m_left = XLEN + 1;
            m_exp  = ref_res(op, a, b);
            m_tag  = tag_of(op, a, b);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (m_left > 0), "R8 busy", {31'b0, busy}, {31'b0, m_left > 0});
         chk(done == m_done, "R7 done timing", {31'b0, done}, {31'b0, m_done});
         if (m_done) chk(result == m_res, m_tag, result, m_res);
         else        chk(result == m_res, "R9 result held", result, m_res);
      end
   end

   task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      start = 1'b1; op = o; a = x; b = y;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
      issue(o, x, y);
      repeat (XLEN + 2) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 1'b0, "R10 reset busy", {31'b0, busy}, 32'd0);
      chk(done == 1'b0, "R10 reset done", {31'b0, done}, 32'd0);
      chk(result == '0, "R10 reset result", result, 32'd0);
      rst_n = 1'b1;

      // R1 / R2 products across sign mixes
      run(2'd0, 32'd8, 32'd9);
      run(2'd1, 32'd8, 32'd9);
      run(2'd0, 32'hFFFF_FFF9, 32'd123456);
      run(2'd1, 32'hFFFF_FFF9, 32'd123456);
      run(2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      run(2'd1, 32'h8000_0000, 32'h8000_0000);
      run(2'd0, 32'h8000_0000, 32'hFFFF_FFFF);
      run(2'd1, 32'hDEAD_BEEF, 32'h1234_5678);
      // R3 / R4 truncation toward zero, remainder sign
      run(2'd2, 32'd74, 32'd8);
      run(2'd3, 32'd74, 32'd8);
      run(2'd2, 32'hFFFF_FFB6, 32'd8);
      run(2'd3, 32'hFFFF_FFB6, 32'd8);
      run(2'd2, 32'd74, 32'hFFFF_FFF8);
      run(2'd3, 32'd74, 32'hFFFF_FFF8);
      run(2'd3, 32'hFFFF_FFB6, 32'hFFFF_FFF8);
      run(2'd2, 32'd5, 32'd7);
      run(2'd2, 32'h8000_0000, 32'd2);
      // R5 divide by zero
      run(2'd2, 32'd77, 32'd0);
      run(2'd2, 32'hFFFF_FF00, 32'd0);
      run(2'd3, 32'hFFFF_FF00, 32'd0);
      // R6 signed overflow
      run(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
      run(2'd3, 32'h8000_0000, 32'hFFFF_FFFF);

      // R8 start while busy is ignored
      issue(2'd0, 32'd1000, 32'd3);
      repeat (5) @(negedge clk);
      start = 1'b1; op = 2'd2; a = 32'd99; b = 32'd0;
      @(negedge clk);
      start = 1'b0;
      repeat (XLEN) @(negedge clk);
      chk(busy == 1'b0, "R8 no extra run", {31'b0, busy}, 32'd0);

      // R7 back-to-back: new start presented during the done cycle
      issue(2'd3, 32'd1001, 32'd10);
      repeat (XLEN) @(negedge clk);
      start = 1'b1; op = 2'd1; a = 32'hFFFF_FFFF; b = 32'd5;
      @(negedge clk);
      start = 1'b0;
      repeat (XLEN + 3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule